// File: doc/BRIEF.md
# High-Speed Transmitter Slew-Rate Calibration Sequencer

This block runs the slew-rate calibration of a high-speed serial transmitter without software involvement. On a start pulse it powers a ring oscillator and waits for it to settle. It then enables a free-running clock, loads the measurement window length into a frequency meter and enables the meter. The block samples the meter's valid flag at a fixed poll interval until the flag is seen or a timeout expires, and captures the meter count in either case. It then shuts down the meter and the free-run clock in that order.

The 3-bit slew-control code is derived from the captured count. A fixed product of the reference frequency in MHz, a coefficient and the window length is divided by the count in a bit-serial restoring divider. The quotient is then scaled down by 1000 with round-to-nearest and saturated at 7. A zero count selects a fixed fallback code. The code is written first, and only then is the oscillator turned off and a one-cycle done pulse raised. A nonzero override value applied with the start pulse is used as the code directly, and no measurement takes place.

Top module: `slew_cal_seq`

## Requirements
- R1: If `force_code_i` is nonzero when a start pulse is accepted, `code_o` takes that value and `done_o` pulses on the next cycle. The oscillator, free-run and meter enables stay low.
- R2: After `osc_en_o` rises, `frck_en_o` rises exactly SETTLE_US × CYC_PER_US cycles later.
- R3: `cycle_cnt_o` holds CYCLE_CNT (1024) whenever `meter_en_o` is high. `meter_en_o` is high only while `frck_en_o` is high, and `frck_en_o` is high only while `osc_en_o` is high.
- R4: `meter_valid_i` is sampled once every POLL_US × CYC_PER_US cycles. When it is high at the first sample, `meter_en_o` stays high for exactly POLL_CYC + 2 cycles.
- R5: If valid is never seen, the count is captured after TIMEOUT_US / POLL_US polls. `meter_en_o` is then high for exactly NPOLL × POLL_CYC + 2 cycles, and the code is still computed from the captured count.
- R6: Teardown happens in three separate steps. `meter_en_o` falls first and `frck_en_o` falls on a later cycle. `osc_en_o` falls last, on the cycle `done_o` is raised, with `code_o` already updated.
- R7: For a nonzero count c, `code_o` = round((REF_MHZ × COEF × 1024 / c, truncated) / 1000), with halves rounded up. With the defaults the dividend is 452608, so c=181 gives 3 and c=182 gives 2.
- R8: A captured count of zero gives code 3.
- R9: A computed code above 7 is clamped to 7.
- R10: `done_o` is high for exactly one cycle per accepted start.
- R11: A start pulse that arrives while a calibration is running is ignored, together with its override value. No extra done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start request |
| force_code_i | input | 3 | Override code; nonzero skips the measurement |
| meter_valid_i | input | 1 | Frequency meter result valid |
| meter_count_i | input | 24 | Frequency meter count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-run clock enable |
| meter_en_o | output | 1 | Frequency meter enable |
| cycle_cnt_o | output | 24 | Measurement window length for the meter |
| code_o | output | 3 | Slew-control code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The divider path is tried with counts that put the quotient just above and just below a rounding half-step (181 and 182). These separate round-to-nearest from truncation. Other counts land mid-range, and counts of 60 and 1 overflow the 3-bit field, which shows whether saturation is applied or the value wraps. A zero count with valid raised shows whether the fallback is taken rather than a divide by zero. A run with valid never raised shows that the timeout path still completes and uses the captured count. A forced value and a second start issued during a run show the skip path and the busy lockout.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOAD,
    ST_MEAS,
    ST_POLL,
    ST_READ,
    ST_MOFF,
    ST_FOFF,
    ST_DIV,
    ST_WRITE,
    ST_OSCOFF
  } cal_state_e;
endpackage

// File: rtl/slew_cal_div.sv
module slew_cal_div #(
  parameter int DW = 19,
  parameter int VW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          busy_o,
  output logic          valid_o,
  output logic [DW-1:0] quot_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam int PW = DW + VW;

  logic [DW-1:0] acc_q, hold_q;
  logic [VW-1:0] rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, valid_q;
  logic [VW:0]   trial, diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, acc_q[DW-1]};
    fits  = trial >= {1'b0, dvs_q};
    diff  = trial - {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      hold_q  <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      acc_q   <= dividend_i;
      hold_q  <= dividend_i;
      rem_q   <= '0;
      dvs_q   <= divisor_i;
      cnt_q   <= CW'(DW - 1);
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= fits ? diff[VW-1:0] : trial[VW-1:0];
      acc_q <= {acc_q[DW-2:0], fits};
      if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign quot_o  = acc_q;

  // R7: quotient is the exact floor of dividend / divisor
  a_r7_quot_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (PW'(quot_o) * PW'(dvs_q) <= PW'(hold_q)));
  a_r7_quot_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (PW'(quot_o) * PW'(dvs_q) + PW'(dvs_q) > PW'(hold_q)));
  a_r7_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(busy_o));
endmodule

// File: rtl/slew_cal_round.sv
module slew_cal_round #(
  parameter int QW        = 19,
  parameter int ROUND_DIV = 1000,
  parameter int CODE_W    = 3
) (
  input  logic [QW-1:0]     quot_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  // round-to-nearest of quot/ROUND_DIV, saturated: count thresholds crossed
  always_comb begin
    code_o = '0;
    for (int k = 1; k <= CODE_MAX; k++) begin
      if (64'(quot_i) >= 64'(k * ROUND_DIV - ROUND_DIV / 2)) code_o = CODE_W'(k);
    end
  end
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq #(
  parameter int CYC_PER_US = 26,
  parameter int SETTLE_US  = 1,
  parameter int POLL_US    = 10,
  parameter int TIMEOUT_US = 200,
  parameter int REF_MHZ    = 26,
  parameter int COEF       = 17,
  parameter int CYCLE_CNT  = 1024,
  parameter int ROUND_DIV  = 1000,
  parameter int FALLBACK   = 3,
  parameter int CNT_W      = 24,
  parameter int CODE_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] force_code_i,
  input  logic              meter_valid_i,
  input  logic [CNT_W-1:0]  meter_count_i,
  output logic              osc_en_o,
  output logic              frck_en_o,
  output logic              meter_en_o,
  output logic [CNT_W-1:0]  cycle_cnt_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  import slew_cal_pkg::*;

  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int POLL_CYC   = POLL_US * CYC_PER_US;
  localparam int NPOLL      = TIMEOUT_US / POLL_US;
  localparam int TMR_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int PIDX_W     = $clog2(NPOLL + 1);
  localparam int PROD       = REF_MHZ * COEF * CYCLE_CNT;
  localparam int DW         = $clog2(PROD + 1);

  cal_state_e        state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [CNT_W-1:0]  cnt_q, cyc_q;
  logic [CODE_W-1:0] code_q, rnd_code;
  logic              osc_q, frck_q, meter_q, done_q, div_go;
  logic              div_busy, div_valid;
  logic [DW-1:0]     quot;

  assign div_go = (state_q == ST_FOFF) && (cnt_q != '0);

  slew_cal_div #(.DW(DW), .VW(CNT_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_go),
    .dividend_i(DW'(PROD)),
    .divisor_i (cnt_q),
    .busy_o    (div_busy),
    .valid_o   (div_valid),
    .quot_o    (quot)
  );

  slew_cal_round #(.QW(DW), .ROUND_DIV(ROUND_DIV), .CODE_W(CODE_W)) u_round (
    .quot_i(quot),
    .code_o(rnd_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      pidx_q  <= '0;
      cnt_q   <= '0;
      cyc_q   <= '0;
      code_q  <= '0;
      osc_q   <= 1'b0;
      frck_q  <= 1'b0;
      meter_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (force_code_i != '0) begin
            code_q <= force_code_i;
            done_q <= 1'b1;
          end else begin
            osc_q   <= 1'b1;
            tmr_q   <= TMR_W'(SETTLE_CYC - 1);
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_q == '0) begin
            frck_q  <= 1'b1;
            state_q <= ST_LOAD;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_LOAD: begin
          cyc_q   <= CNT_W'(CYCLE_CNT);
          state_q <= ST_MEAS;
        end
        ST_MEAS: begin
          meter_q <= 1'b1;
          tmr_q   <= TMR_W'(POLL_CYC - 1);
          pidx_q  <= '0;
          state_q <= ST_POLL;
        end
        ST_POLL: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (meter_valid_i || pidx_q == PIDX_W'(NPOLL - 1)) begin
            state_q <= ST_READ;  // timeout falls through to the read
          end else begin
            pidx_q <= pidx_q + 1'b1;
            tmr_q  <= TMR_W'(POLL_CYC - 1);
          end
        end
        ST_READ: begin
          cnt_q   <= meter_count_i;
          state_q <= ST_MOFF;
        end
        ST_MOFF: begin
          meter_q <= 1'b0;
          state_q <= ST_FOFF;
        end
        ST_FOFF: begin
          frck_q  <= 1'b0;
          state_q <= (cnt_q == '0) ? ST_WRITE : ST_DIV;
        end
        ST_DIV: if (div_valid && !div_busy) state_q <= ST_WRITE;
        ST_WRITE: begin
          code_q  <= (cnt_q == '0) ? CODE_W'(FALLBACK) : rnd_code;
          state_q <= ST_OSCOFF;
        end
        ST_OSCOFF: begin
          osc_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign osc_en_o    = osc_q;
  assign frck_en_o   = frck_q;
  assign meter_en_o  = meter_q;
  assign cycle_cnt_o = cyc_q;
  assign code_o      = code_q;
  assign done_o      = done_q;

  a_r1_force_skips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> ($past(force_code_i) == '0));
  a_r3_meter_needs_frck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meter_en_o |-> (frck_en_o && cycle_cnt_o == CNT_W'(CYCLE_CNT)));
  a_r3_frck_needs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frck_en_o |-> osc_en_o);
  a_r6_frck_after_meter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frck_en_o) |-> !$past(meter_en_o));
  a_r6_osc_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (done_o && !$past(frck_en_o)));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_busy_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && !done_o) |=> !(done_o && !$fell(osc_en_o)));
endmodule

// File: tb/slew_cal_seq_tb.sv
module slew_cal_seq_tb;
  localparam int CPU    = 4;
  localparam int SETTLE = CPU * 1;
  localparam int POLL   = CPU * 10;
  localparam int NPOLL  = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  force_code_i = '0;
  logic        meter_valid_i;
  logic [23:0] meter_count_i = '0;
  logic        osc_en_o, frck_en_o, meter_en_o, done_o;
  logic [23:0] cycle_cnt_o;
  logic [2:0]  code_o;

  logic valid_mode = 1'b0;
  assign meter_valid_i = meter_en_o & valid_mode;

  slew_cal_seq #(.CYC_PER_US(CPU)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .force_code_i(force_code_i), .meter_valid_i(meter_valid_i),
    .meter_count_i(meter_count_i), .osc_en_o(osc_en_o),
    .frck_en_o(frck_en_o), .meter_en_o(meter_en_o),
    .cycle_cnt_o(cycle_cnt_o), .code_o(code_o), .done_o(done_o)
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0, dones = 0, osc_rises = 0;
  int exp_q[$];
  bit exp_timeout = 0, exp_force = 0;
  int t_osc, t_meter, t_mfall, t_ffall, t_ofall;
  logic p_osc = 0, p_frck = 0, p_meter = 0, p_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int c);
    int q, r;
    if (c == 0) return 3;
    q = 452608 / c;
    r = (q + 500) / 1000;
    return (r > 7) ? 7 : r;
  endfunction

  // monitor / scoreboard
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (osc_en_o && !p_osc) begin t_osc = cyc; osc_rises++; end
      if (frck_en_o && !p_frck) chk(cyc - t_osc == SETTLE, "R2 settle", cyc - t_osc, SETTLE);
      if (meter_en_o && !p_meter) begin
        t_meter = cyc;
        chk(cycle_cnt_o == 1024, "R3 cycle count", int'(cycle_cnt_o), 1024);
      end
      if (!meter_en_o && p_meter) begin
        t_mfall = cyc;
        if (exp_timeout) chk(cyc - t_meter == NPOLL * POLL + 2, "R5 timeout window", cyc - t_meter, NPOLL * POLL + 2);
        else chk(cyc - t_meter == POLL + 2, "R4 poll window", cyc - t_meter, POLL + 2);
      end
      if (!frck_en_o && p_frck) t_ffall = cyc;
      if (!osc_en_o && p_osc) t_ofall = cyc;
      if (p_done) chk(!done_o, "R10 done width", int'(done_o), 0);
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) chk(0, "R11 unexpected done", int'(code_o), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(code_o) == e, "R7/R8/R9/R1 code", int'(code_o), e);
        end
        if (!exp_force)
          chk(t_mfall < t_ffall && t_ffall < t_ofall && t_ofall == cyc, "R6 teardown order",
              t_ofall - t_ffall, 1);
      end
    end
    p_osc = osc_en_o; p_frck = frck_en_o; p_meter = meter_en_o; p_done = done_o;
  end

  task automatic run(input int cnt, input bit vld, input int frc, input bit poke);
    int d0, r0;
    d0 = dones; r0 = osc_rises;
    meter_count_i = 24'(cnt);
    valid_mode = vld;
    exp_timeout = !vld;
    exp_force = (frc != 0);
    force_code_i = 3'(frc);
    exp_q.push_back((frc != 0) ? frc : exp_code(cnt));
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) begin start_i = 1'b0; force_code_i = '0; end
    if (poke) begin
      repeat (8) @(negedge clk_i);
      force_code_i = 3'd6; start_i = 1'b1;  // R11: ignored while busy
      @(negedge clk_i) begin start_i = 1'b0; force_code_i = '0; end
    end
    wait (dones == d0 + 1);
    repeat (20) @(negedge clk_i);
    chk(dones == d0 + 1, "R11 one done per start", dones - d0, 1);
    if (frc != 0) chk(osc_rises == r0, "R1 no oscillator", osc_rises - r0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!osc_en_o && !frck_en_o && !meter_en_o && !done_o, "R3 reset enables", int'(osc_en_o), 0);
    chk(code_o == 0 && cycle_cnt_o == 0, "R10 reset outputs", int'(code_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run(0,   1, 5, 0);  // R1 forced
    run(151, 1, 0, 0);  // R7 -> 3
    run(100, 1, 0, 0);  // R7 -> 5
    run(181, 1, 0, 0);  // R7 rounding up at half step
    run(182, 1, 0, 0);  // R7 just below half step
    run(0,   1, 0, 0);  // R8 fallback
    run(60,  1, 0, 0);  // R9 clamp
    run(1,   1, 0, 0);  // R9 clamp large quotient
    run(113, 0, 0, 0);  // R5 timeout -> 4
    run(300, 1, 0, 1);  // R11 start during run
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule